// File: doc/BRIEF.md
# Wide-Fetch Byte Prefetch Buffer

This block sits between a requester that reads one byte at a time and a slow backing memory that returns a full 32-bit word per access. For any byte request it fetches the aligned four-byte word that contains the byte and keeps that word, its word address (the tag) and a valid flag in a single-line buffer. Requests that land anywhere in the buffered word are answered in the same cycle without touching the memory. A request outside the word stalls the requester while the memory fetch runs, so a sequential walk pays the memory latency once every four bytes, and a jump pays it in full.

The requester holds `req_valid` and `req_addr` steady until it sees `ready` high; that cycle completes the transfer and `rdata` carries the byte. The backing memory is read over a simple timed port: `mem_rd` is high for exactly `LAT` cycles with a steady `mem_addr`, and the word on `mem_rdata` is captured in the last of those cycles. A `flush` pulse invalidates the buffer so that the next access refetches from memory.

Top module: `byte_prefetch_buf`

## Requirements
- R1: After reset the buffer holds no valid word, `ready` and `mem_rd` are low, and the first request is treated as a miss.
- R2: A request whose word is not buffered keeps `ready` low for exactly LAT+1 cycles (one decision cycle plus LAT memory cycles), after which `ready` rises with the requested byte.
- R3: During a fetch `mem_rd` is high for exactly LAT consecutive cycles and `mem_addr` equals `req_addr[AW-1:2]` throughout.
- R4: Byte lanes are little-endian: address bits [1:0] = k return `mem_rdata[8k+7:8k]` of the fetched word.
- R5: A request whose `req_addr[AW-1:2]` matches the buffered tag while the buffer is valid sees `ready` high in the same cycle, and no memory read follows.
- R6: After a miss on byte N, every other byte of the same aligned word is served as a hit.
- R7: A `flush` pulse clears the valid flag at the next clock edge; the next request to the previously buffered word is a miss.
- R8: When `flush` is high in the last memory cycle of a fetch, the flush wins: the fetched word is discarded, and the still-pending request starts a new fetch, so its total stall is 2*(LAT+1) cycles.
- R9: A hit presented in the same cycle as `flush` is still served in that cycle with the correct byte; only later requests see the empty buffer.
- R10: `flush` in an earlier cycle of a fetch, not its last one, has no effect on that fetch: the stall stays LAT+1 cycles and the word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Byte request present; held until `ready` |
| req_addr | input | AW | Byte address of the request |
| flush | input | 1 | Invalidate the buffered word |
| ready | output | 1 | Request completed this cycle, `rdata` valid |
| rdata | output | 8 | Requested byte |
| mem_rd | output | 1 | Memory read in progress |
| mem_addr | output | AW-2 | Word address presented to memory |
| mem_rdata | input | 32 | Word returned by memory, sampled in the last read cycle |

## Verification
The two functions that can coincide are the fill that ends a fetch and an invalidating flush; the same pairing arises between a same-cycle hit and a flush. The bench raises `flush` on exactly the final memory cycle of a fetch and judges the outcome by the requester-visible stall, which must double to 2*(LAT+1) with a second burst of LAT `mem_rd` cycles, and it contrasts that with a flush in an earlier fetch cycle, which must leave the stall at LAT+1. For the hit case it presents a hit together with `flush`, expects the byte in that cycle, and then expects the neighbouring byte to miss.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fetch_state_e;

  // Little-endian lane pick: lane k is bits [8k+7:8k]
  function automatic logic [7:0] lane_of(input logic [31:0] word, input logic [1:0] lane);
    return word[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/pfb_line.sv
module pfb_line #(
  parameter int TW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill,
  input  logic          flush,
  input  logic [TW-1:0] fill_tag,
  input  logic [31:0]   fill_word,
  input  logic [TW-1:0] look_tag,
  output logic          hit,
  output logic          line_valid,
  output logic [31:0]   line_word
);

  logic [TW-1:0] line_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_valid <= 1'b0;
      line_tag   <= '0;
      line_word  <= '0;
    end else if (flush) begin
      line_valid <= 1'b0;
    end else if (fill) begin
      line_valid <= 1'b1;
      line_tag   <= fill_tag;
      line_word  <= fill_word;
    end
  end

  assign hit = line_valid && (line_tag == look_tag);

endmodule

// File: rtl/pfb_miss_ctrl.sv
module pfb_miss_ctrl #(
  parameter int TW  = 14,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] start_tag,
  output logic          busy,
  output logic          fill,
  output logic [TW-1:0] fetch_tag
);
  import pfb_pkg::*;

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  fetch_state_e  state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      fetch_tag <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_WAIT;
            cnt       <= '0;
            fetch_tag <= start_tag;
          end
        end
        ST_WAIT: begin
          if (cnt == LAST) state <= ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT);
  assign fill = busy && (cnt == LAST);

endmodule

// File: rtl/pfb_lane_mux.sv
module pfb_lane_mux (
  input  logic [31:0] word,
  input  logic [1:0]  lane,
  output logic [7:0]  byte_out
);
  import pfb_pkg::*;

  always_comb byte_out = lane_of(word, lane);

endmodule

// File: rtl/byte_prefetch_buf.sv
module byte_prefetch_buf #(
  parameter int AW  = 16,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          flush,
  output logic          ready,
  output logic [7:0]    rdata,
  output logic          mem_rd,
  output logic [AW-3:0] mem_addr,
  input  logic [31:0]   mem_rdata
);

  localparam int TW = AW - 2;

  logic          hit;
  logic          line_valid;
  logic [31:0]   line_word;
  logic          busy;
  logic          fill;
  logic          miss_start;
  logic [TW-1:0] fetch_tag;
  logic [TW-1:0] look_tag;

  assign look_tag   = req_addr[AW-1:2];
  assign miss_start = req_valid && !hit && !busy;

  pfb_line #(.TW(TW)) u_line (
    .clk        (clk),
    .rst        (rst),
    .fill       (fill),
    .flush      (flush),
    .fill_tag   (fetch_tag),
    .fill_word  (mem_rdata),
    .look_tag   (look_tag),
    .hit        (hit),
    .line_valid (line_valid),
    .line_word  (line_word)
  );

  pfb_miss_ctrl #(.TW(TW), .LAT(LAT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (miss_start),
    .start_tag (look_tag),
    .busy      (busy),
    .fill      (fill),
    .fetch_tag (fetch_tag)
  );

  pfb_lane_mux u_mux (
    .word     (line_word),
    .lane     (req_addr[1:0]),
    .byte_out (rdata)
  );

  assign ready    = req_valid && hit && !busy;
  assign mem_rd   = busy;
  assign mem_addr = fetch_tag;

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int AW  = 16,
  parameter int LAT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          ready,
  input logic          flush,
  input logic          hit,
  input logic          busy,
  input logic          fill,
  input logic          line_valid,
  input logic [AW-3:0] mem_addr
);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else              busy_run <= busy_run + 1;
  end

  a_r3_fetch_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < LAT));

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (rst)
    busy && !fill |=> busy && $stable(mem_addr));

  a_r2_miss_starts: assert property (@(posedge clk) disable iff (rst)
    req_valid && !hit && !busy |=> busy);

  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    fill && !flush |=> line_valid);

  a_r5_hit_no_fetch: assert property (@(posedge clk) disable iff (rst)
    ready |=> !busy);

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !line_valid);

  a_r8_flush_beats_fill: assert property (@(posedge clk) disable iff (rst)
    fill && flush |=> !line_valid && !ready);

  a_r2_no_ready_in_fetch: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);

endmodule

bind byte_prefetch_buf pfb_checker #(.AW(AW), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .ready      (ready),
  .flush      (flush),
  .hit        (hit),
  .busy       (busy),
  .fill       (fill),
  .line_valid (line_valid),
  .mem_addr   (mem_addr)
);

// File: tb/sim_byte_prefetch_buf.sv
`timescale 1ns/1ps
module sim_byte_prefetch_buf;
  localparam int AW  = 16;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          flush = 1'b0;
  logic          ready;
  logic [7:0]    rdata;
  logic          mem_rd;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_rdata;

  int checks = 0;
  int errors = 0;

  bit            m_valid = 1'b0;
  logic [AW-3:0] m_tag = '0;

  always #4 clk = ~clk;

  byte_prefetch_buf #(.AW(AW), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .flush(flush), .ready(ready), .rdata(rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [AW-3:0] w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
    logic [31:0] w;
    w = mem_word(a[AW-1:2]) >> (a[1:0] * 8);
    return w[7:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // flush_at: cycle index of the request at which flush is driven (-1: none)
  task automatic access(input logic [AW-1:0] a, input int flush_at, input string rq);
    int  stall;
    int  rd_n;
    int  exp_stall;
    int  exp_rd;
    bit  exp_hit;
    bit  fl_at_ready;
    exp_hit   = m_valid && (m_tag == a[AW-1:2]);
    exp_stall = exp_hit ? 0 : ((flush_at == LAT) ? 2 * (LAT + 1) : LAT + 1);
    exp_rd    = exp_hit ? 0 : ((flush_at == LAT) ? 2 * LAT : LAT);
    stall = 0;
    rd_n  = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    flush     = (flush_at == 0);
    forever begin
      #1;
      if (ready) break;
      stall++;
      if (mem_rd) begin
        rd_n++;
        chk(mem_addr == a[AW-1:2], "R3", "mem_addr", mem_addr, a[AW-1:2]);
      end
      if (stall > 100) begin
        chk(1'b0, rq, "stall timeout", stall, exp_stall);
        break;
      end
      @(negedge clk);
      flush = (stall == flush_at);
    end
    fl_at_ready = flush;
    chk(stall == exp_stall, rq, "stall cycles", stall, exp_stall);
    chk(rd_n == exp_rd, "R3", "mem_rd cycles", rd_n, exp_rd);
    chk(rdata == exp_byte(a), "R4", "rdata", rdata, exp_byte(a));
    @(negedge clk);
    req_valid = 1'b0;
    flush     = 1'b0;
    m_valid   = !fl_at_ready;
    m_tag     = a[AW-1:2];
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle outputs after reset
    chk(ready == 1'b0, "R1", "ready after reset", ready, 0);
    chk(mem_rd == 1'b0, "R1", "mem_rd after reset", mem_rd, 0);
    // R1/R2: first request misses
    access(16'h0123, -1, "R1");
    // R6: remaining lanes of the word hit; R4 checks each lane
    access(16'h0120, -1, "R6");
    access(16'h0121, -1, "R6");
    access(16'h0122, -1, "R6");
    access(16'h0123, -1, "R5");
    // R2: next word is a fresh miss
    access(16'h0124, -1, "R2");
    access(16'h0127, -1, "R5");
    // R7: standalone flush forces refetch
    pulse_flush();
    access(16'h0125, -1, "R7");
    // R8: flush in final fetch cycle doubles the stall
    access(16'h0200, LAT, "R8");
    access(16'h0201, -1, "R8");
    // R10: early flush during fetch is harmless
    access(16'h0300, 1, "R10");
    access(16'h0303, -1, "R10");
    // R9: hit together with flush is served, neighbour then misses
    access(16'h0301, 0, "R9");
    access(16'h0302, -1, "R9");
    // random mix
    a = 16'h0400;
    for (int i = 0; i < 300; i++) begin
      int r;
      int fa;
      r = int'($urandom % 10);
      if (r < 6)      a = a + 1'b1;
      else if (r < 8) a = AW'($urandom % 64);
      else            a = AW'($urandom);
      fa = -1;
      if ($urandom % 16 == 0) fa = ($urandom % 2 == 0) ? 0 : LAT;
      if ($urandom % 25 == 0) pulse_flush();
      access(a, fa, (m_valid && m_tag == a[AW-1:2]) ? "R5" : "R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule